// File: doc/BRIEF.md
# Grouped One-Hot Step Sequencer

This block runs a fixed actuator step sequence, such as a pneumatic or solenoid cycle, with the steps gathered into groups. Each group owns one set/clear storage flag, so the running state is one-hot across groups. A start pulse arms the first group. After that, each group hands over to the next when the completion sensor of its last step fires. The new flag takes over on the same clock edge that drops the old one, so two groups are never active together. The completion sensor of the final group returns the sequencer to idle.

Actuator outputs are formed from the group flags. An output is the OR of one term for each group in which it must be energised. A term is either the bare group flag, which keeps the output on for the whole group, or the flag ANDed with that output's enabling sensor, which turns the output on partway through the group. Two parameters fix the group-to-output mapping and which terms are gated. A group boundary falls wherever an output must be switched off, so opposing solenoids never share a group.

Sensor inputs are taken as levels that are already synchronised. There is an asynchronous active-low reset and a synchronous clear.

Top module: `seq_ctrl`

## Requirements
- R1: At most one bit of grp_o is high in any cycle.
- R2: From idle (grp_o all zero), start_i high sets grp_o[0] on the next rising edge.
- R3: While grp_o[g] is high for g below N_GRP-1, done_i[g] high moves the sequencer to grp_o[g+1] on the next edge, and grp_o[g] clears on that same edge.
- R4: While the final flag grp_o[N_GRP-1] is high, done_i[N_GRP-1] high returns the sequencer to idle on the next edge.
- R5: Bit o*N_GRP+g of ON_MAP selects output o in group g. When the matching GATE_MAP bit is 0, act_o[o] is high for the whole time grp_o[g] is high. Default maps: output 0 is on in groups 0 and 2, and output 1 is on in group 1.
- R6: When the GATE_MAP bit is 1, the term for output o in group g is high only while en_i[o] is also high. Default maps: output 2 is gated in group 1 and ungated in group 3, and output 3 is gated in groups 0 and 2.
- R7: act_o[o] is the OR of its terms over all groups, and it is low in every group that is not mapped to it and while idle.
- R8: start_i has no effect while any grp_o bit is high.
- R9: done_i[g] has no effect unless grp_o[g] is high.
- R10: clr_i high forces act_o to zero in the same cycle and clears grp_o on the next edge. It overrides a start or done that arrives in the same cycle. rst_ni low clears grp_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all flags; forces outputs off |
| start_i | input | 1 | Start request, accepted only when idle |
| done_i | input | N_GRP | Completion sensor for the last step of each group |
| en_i | input | N_OUT | Enabling sensor for each output's gated terms |
| grp_o | output | N_GRP | One-hot group-active flags |
| act_o | output | N_OUT | Actuator drive outputs |

## Verification
The bench drives start_i while the sequencer is busy. A design that failed to block it would re-arm group 0 alongside the active group and break the one-hot state. It raises done_i for groups that are not active; a design that decoded done without its group flag would skip groups. It checks the handover edge for overlap, since a flag that is cleared only after its successor is seen would leave two groups, and opposing solenoids, on for one cycle. It also applies clr_i together with start and done, and it toggles en_i inside gated groups to catch a gated term wired as a whole-group term.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // bit index of output o / group g inside the mapping vectors
  function automatic int map_idx(input int o, input int g, input int n_grp);
    return o * n_grp + g;
  endfunction
endpackage

// File: rtl/seq_grp_flag.sv
module seq_grp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclr_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (sclr_i)  q_q <= 1'b0;
    else if (clr_i)   q_q <= 1'b0;
    else if (set_i)   q_q <= 1'b1;
  end

  assign q_o = q_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && !sclr_i) |=> q_o);
  p_clr_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_i || clr_i) |=> !q_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && !sclr_i) |=> q_o == $past(q_o));
endmodule

// File: rtl/seq_out_map.sv
module seq_out_map #(
  parameter int N_GRP = 4,
  parameter int N_OUT = 4,
  parameter logic [N_OUT*N_GRP-1:0] ON_MAP   = '0,
  parameter logic [N_OUT*N_GRP-1:0] GATE_MAP = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GRP-1:0] grp_i,
  input  logic [N_OUT-1:0] en_i,
  input  logic             kill_i,
  output logic [N_OUT-1:0] act_o
);
  import seq_pkg::*;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_GRP-1:0] term;
    for (genvar g = 0; g < N_GRP; g++) begin : g_term
      localparam int IDX = map_idx(o, g, N_GRP);
      if (!ON_MAP[IDX]) begin : g_none
        assign term[g] = 1'b0;
      end else if (GATE_MAP[IDX]) begin : g_gated
        assign term[g] = grp_i[g] & en_i[o];
      end else begin : g_full
        assign term[g] = grp_i[g];
        p_full_term_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (grp_i[g] && !kill_i) |-> act_o[o]);
      end
    end
    assign act_o[o] = (|term) & ~kill_i;
  end

  p_idle_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_i == '0) |-> (act_o == '0));
  p_kill_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> (act_o == '0));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int N_GRP = 4,
  parameter int N_OUT = 4,
  parameter logic [N_OUT*N_GRP-1:0] ON_MAP   = 16'h5A25,
  parameter logic [N_OUT*N_GRP-1:0] GATE_MAP = 16'h5200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [N_GRP-1:0] done_i,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_GRP-1:0] grp_o,
  output logic [N_OUT-1:0] act_o
);
  localparam int LAST = N_GRP - 1;

  logic [N_GRP-1:0] grp_q;
  logic [N_GRP-1:0] set_w;
  logic [N_GRP-1:0] clr_w;
  logic             busy;

  assign busy = |grp_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    if (g == 0) begin : g_first
      assign set_w[g] = start_i & ~busy;
    end else begin : g_next
      assign set_w[g] = grp_q[g-1] & done_i[g-1];
    end
    // handover: cleared by successor's set, last group by its own done
    if (g == LAST) begin : g_last
      assign clr_w[g] = grp_q[g] & done_i[g];
    end else begin : g_mid
      assign clr_w[g] = set_w[g+1];
    end

    seq_grp_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sclr_i (clr_i),
      .set_i  (set_w[g]),
      .clr_i  (clr_w[g]),
      .q_o    (grp_q[g])
    );
  end

  seq_out_map #(
    .N_GRP    (N_GRP),
    .N_OUT    (N_OUT),
    .ON_MAP   (ON_MAP),
    .GATE_MAP (GATE_MAP)
  ) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grp_i  (grp_q),
    .en_i   (en_i),
    .kill_i (clr_i),
    .act_o  (act_o)
  );

  assign grp_o = grp_q;

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_o));
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && !clr_i) |=> (grp_o == N_GRP'(1)));
  p_final_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_o[LAST] && done_i[LAST] && !clr_i) |=> (grp_o == '0));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (grp_o == '0));

  if (N_GRP > 1) begin : g_chk_multi
    p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && !grp_o[0]) |=> !grp_o[0]);
    p_handover_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_o[0] && done_i[0] && !clr_i) |=> (grp_o == N_GRP'(2)));
  end
endmodule

// File: tb/tb_seq_ctrl.sv
`timescale 1ns/1ps
module tb_seq_ctrl;
  localparam int NG = 4;
  localparam int NO = 4;
  localparam logic [NO*NG-1:0] ONM = 16'h5A25;
  localparam logic [NO*NG-1:0] GTM = 16'h5200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic start = 1'b0;
  logic [NG-1:0] done = '0;
  logic [NO-1:0] en = '0;
  logic [NG-1:0] grp;
  logic [NO-1:0] act;

  int n_chk = 0;
  int n_fail = 0;
  logic [NG-1:0] m_grp = '0;

  always #10 clk = ~clk;

  seq_ctrl #(.N_GRP(NG), .N_OUT(NO), .ON_MAP(ONM), .GATE_MAP(GTM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .start_i(start),
    .done_i(done), .en_i(en), .grp_o(grp), .act_o(act)
  );

  function automatic logic [NG-1:0] nxt(input logic [NG-1:0] cur, input logic st,
                                        input logic [NG-1:0] dn, input logic cl);
    if (cl) return '0;
    if (cur == '0) return st ? NG'(1) : '0;
    for (int g = 0; g < NG; g++)
      if (cur[g] && dn[g]) return (g == NG-1) ? '0 : NG'(1) << (g+1);
    return cur;
  endfunction

  function automatic logic [NO-1:0] exp_act(input logic [NG-1:0] cur,
                                            input logic [NO-1:0] e, input logic cl);
    logic [NO-1:0] r;
    r = '0;
    for (int o = 0; o < NO; o++)
      for (int g = 0; g < NG; g++)
        if (cur[g] && ONM[o*NG+g] && (!GTM[o*NG+g] || e[o])) r[o] = 1'b1;
    return cl ? '0 : r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // apply inputs, check outputs before the edge, advance the model
  task automatic cyc(input string tg, input string ta, input logic st,
                     input logic [NG-1:0] dn, input logic [NO-1:0] e, input logic cl);
    @(negedge clk);
    start = st; done = dn; en = e; clr = cl;
    #1;
    chk(tg, 8'(grp), 8'(m_grp));
    chk(ta, 8'(act), 8'(exp_act(m_grp, e, cl)));
    m_grp = nxt(m_grp, st, dn, cl);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    chk("R10 reset grp", 8'(grp), 8'h0);
    chk("R10 reset act", 8'(act), 8'h0);
    rst_n = 1'b1;
    cyc("R7", "R7 idle", 0, '0, '1, 0);
    cyc("R2", "R7", 1, '0, '0, 0);           // start from idle
    cyc("R2", "R6 gated off", 0, 4'b0100, 4'b0000, 0); // done2 inactive
    chk("R9 inactive done", 8'(grp), 8'h1);
    cyc("R9", "R6 gated on", 1, '0, 4'b1000, 0); // start while busy
    cyc("R8", "R5", 0, 4'b0001, '0, 0);      // handover 0->1
    cyc("R3", "R6 gated off g1", 0, '0, 4'b0000, 0);
    chk("R3 no overlap", 8'(grp), 8'h2);
    cyc("R3", "R6 gated on g1", 1, '0, 4'b0100, 0);
    cyc("R8", "R5", 0, 4'b0010, '0, 0);
    cyc("R3", "R7 or g2", 0, '0, 4'b1000, 0);
    cyc("R3", "R7", 0, 4'b0100, '0, 0);
    cyc("R3", "R5 full g3", 0, '0, 4'b0000, 0);
    cyc("R4", "R5", 0, 4'b1000, '0, 0);      // final done
    cyc("R4", "R7 idle", 0, '0, '1, 0);
    chk("R4 idle", 8'(grp), 8'h0);
    cyc("R2", "R7", 1, '0, '0, 0);
    cyc("R10", "R10 kill", 1, 4'b0001, '1, 1); // clear beats done
    cyc("R10", "R7", 1, '0, '0, 1);            // clear beats start
    chk("R10 cleared", 8'(grp), 8'h0);
    cyc("R10", "R7", 0, '0, '0, 0);
    rst_n = 1'b0; #1;
    chk("R10 async rst", 8'(grp), 8'h0);
    m_grp = '0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic st, cl;
      logic [NG-1:0] dn;
      st = ($urandom % 6) == 0;
      cl = ($urandom % 40) == 0;
      dn = '0;
      for (int g = 0; g < NG; g++) dn[g] = ($urandom % 4) == 0;
      cyc("R1 R3 rand", "R7 rand", st, dn, NO'($urandom), cl);
      n_chk++;
      if (!$onehot0(grp)) begin
        n_fail++;
        $display("FAIL R1: got %0h expected onehot0", grp);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule